// File: doc/BRIEF.md
# USB Device Endpoint State Manager

This block holds the control state of up to eight endpoints of a small USB device controller: an enable bit, a configuration byte, a data toggle, an interrupt flag byte and two status bytes for each endpoint. The CPU first writes an endpoint index into a selection register. Every later access through the small register window then reaches the selected endpoint. The packet engine reports each finished transaction on a strobe interface. The strobe sets interrupt flags, loads the status bytes and, on success, flips the data toggle.

A timer watches the line for a single-ended zero. When the SE0 lasts the configured number of clock cycles (the 100 µs bus-reset threshold), the block tears the endpoints down selectively. Endpoint 0 keeps its enable and configuration and loses only its toggle. Every other endpoint is disabled. If the CPU-reset mode input is set, the block also pulses a CPU reset, and the endpoint state stays as the bus reset left it. A per-endpoint reset command clears only the flags and status. A separate clear-toggle command clears the toggle.

Top module: `usb_ep_state_mgr`

## Requirements
- R1: Writing address 5 stores `cpu_wdata[2:0]` as the selected index, and reading address 5 returns it in bits 2:0. Addresses 0..4 then read and write the selected endpoint: 0 control, 1 configuration, 2 interrupt flags, 3 status A, 4 status B. Addresses 6 and 7 read zero.
- R2: While the selected index is not below NUM_EP, addresses 0..4 read zero and writes to them change no endpoint.
- R3: `bus_reset_pulse` is high for exactly one cycle. It rises in the cycle after the clock edge that samples `line_se0` high for the SE0_CYCLES-th consecutive time. It fires once per SE0 period. Any low sample restarts the count.
- R4: A bus reset clears the toggle of endpoint 0 and keeps its enable and configuration. It disables every other endpoint and clears that endpoint's toggle, flags and status. CPU writes and transactions in the same edge do not affect endpoint state.
- R5: `cpu_rst_pulse` is high exactly in the cycles where `bus_reset_pulse` is high and `cpu_rst_mode` was high at the detecting edge.
- R6: Writing the control register with bit 1 set is an endpoint reset. It clears the endpoint's flag byte and both status bytes and keeps the toggle, the enable and the configuration.
- R7: Writing the control register with bit 2 set clears the endpoint's toggle. This can be combined with bit 1 in the same write.
- R8: A transaction strobe (`txn_valid`) with `txn_ok` high flips the toggle of endpoint `txn_ep` if that endpoint is enabled. Control bit 0 writes the enable, and control reads return the enable in bit 0 and the toggle in bit 3.
- R9: While an endpoint is disabled, its toggle, flags and status stay at zero and transaction strobes addressed to it are ignored. Its configuration still accepts writes.
- R10: A transaction strobe for an enabled endpoint ORs `txn_int` into its flags and loads `txn_st0`/`txn_st1` into status A/B. A CPU write to the flag register clears the flags whose data bits are 1.
- R11: If an endpoint reset and a transaction for the same endpoint arrive in the same edge, the flags and status end up zero and the toggle still flips on success, unless clear-toggle is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_se0 | input | 1 | Line is in single-ended zero |
| cpu_rst_mode | input | 1 | Bus reset also pulses a CPU reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 3 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for `cpu_addr` (combinational) |
| txn_valid | input | 1 | Transaction completed strobe |
| txn_ep | input | 3 | Endpoint of the transaction |
| txn_ok | input | 1 | Transaction was successful |
| txn_int | input | 8 | Flags to set |
| txn_st0 | input | 8 | New status A value |
| txn_st1 | input | 8 | New status B value |
| bus_reset_pulse | output | 1 | One-cycle bus reset event |
| cpu_rst_pulse | output | 1 | One-cycle CPU reset request |

## Verification
Two clashes in the same edge carry the risk here. One is a bus reset detection landing while the CPU writes endpoint registers and the packet engine strobes transactions. The other is an endpoint-reset command meeting a transaction on the same endpoint. The bench provokes the first by holding a long SE0 while writing configuration and strobing endpoint 0 on every cycle. It provokes the second by issuing the control write in the same cycle as a successful strobe, with and without clear-toggle. A behavioural model applies the requirement priorities, and every cycle the read data and both pulses are compared against it.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int IDX_W  = 3;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] RA_CTL = 3'd0;
  localparam logic [ADDR_W-1:0] RA_CFG = 3'd1;
  localparam logic [ADDR_W-1:0] RA_INT = 3'd2;
  localparam logic [ADDR_W-1:0] RA_STA = 3'd3;
  localparam logic [ADDR_W-1:0] RA_STB = 3'd4;
  localparam logic [ADDR_W-1:0] RA_SEL = 3'd5;

  localparam int CTL_EN     = 0;
  localparam int CTL_EPRST  = 1;
  localparam int CTL_CLRTGL = 2;
  localparam int CTL_TGL_RD = 3;

  typedef struct packed {
    logic              en;
    logic              tgl;
    logic [DATA_W-1:0] cfg;
    logic [DATA_W-1:0] flags;
    logic [DATA_W-1:0] sta;
    logic [DATA_W-1:0] stb;
  } ep_state_t;

  function automatic logic toggle_next(logic cur, logic flip, logic clr);
    if (clr) return 1'b0;
    return cur ^ flip;
  endfunction

  function automatic logic [DATA_W-1:0] flags_next(logic [DATA_W-1:0] cur,
                                                   logic [DATA_W-1:0] set_m,
                                                   logic [DATA_W-1:0] clr_m,
                                                   logic wipe);
    if (wipe) return '0;
    return (cur | set_m) & ~clr_m;
  endfunction

  function automatic logic [DATA_W-1:0] ctl_view(logic en, logic tgl);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CTL_EN]     = en;
    v[CTL_TGL_RD] = tgl;
    return v;
  endfunction
endpackage

// File: rtl/usb_se0_timer.sv
module usb_se0_timer #(
  parameter int SE0_CYCLES = 4800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_se0,
  output logic se0_hit
);
  localparam int CNT_W = $clog2(SE0_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SE0_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(SE0_CYCLES);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_q <= '0;
    else if (!line_se0)       run_q <= '0;
    else if (run_q != CNT_SAT) run_q <= run_q + 1'b1;
  end

  assign se0_hit = line_se0 && (run_q == CNT_LAST);
endmodule

// File: rtl/usb_ep_slot.sv
module usb_ep_slot
  import usb_ep_pkg::*;
#(
  parameter bit IS_DEFAULT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              wr_ctl,
  input  logic              wr_cfg,
  input  logic              wr_flags,
  input  logic [DATA_W-1:0] wdata,
  input  logic              txn_hit,
  input  logic              txn_ok,
  input  logic [DATA_W-1:0] txn_int,
  input  logic [DATA_W-1:0] txn_st0,
  input  logic [DATA_W-1:0] txn_st1,
  output ep_state_t         state
);
  ep_state_t s_q;
  logic      cmd_rst, cmd_clr;

  assign cmd_rst = wr_ctl && wdata[CTL_EPRST];
  assign cmd_clr = wr_ctl && wdata[CTL_CLRTGL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
    end else if (bus_rst) begin
      s_q.tgl <= 1'b0;
      if (!IS_DEFAULT) begin
        s_q.en    <= 1'b0;
        s_q.flags <= '0;
        s_q.sta   <= '0;
        s_q.stb   <= '0;
      end
    end else if (!s_q.en) begin
      s_q.tgl   <= 1'b0;
      s_q.flags <= '0;
      s_q.sta   <= '0;
      s_q.stb   <= '0;
      if (wr_ctl) s_q.en  <= wdata[CTL_EN];
      if (wr_cfg) s_q.cfg <= wdata;
    end else begin
      if (wr_ctl) s_q.en  <= wdata[CTL_EN];
      if (wr_cfg) s_q.cfg <= wdata;
      s_q.tgl   <= toggle_next(s_q.tgl, txn_hit && txn_ok, cmd_clr);
      s_q.flags <= flags_next(s_q.flags, txn_hit ? txn_int : '0,
                              wr_flags ? wdata : '0, cmd_rst);
      if (cmd_rst) begin
        s_q.sta <= '0;
        s_q.stb <= '0;
      end else if (txn_hit) begin
        s_q.sta <= txn_st0;
        s_q.stb <= txn_st1;
      end
    end
  end

  assign state = s_q;
endmodule

// File: rtl/usb_ep_rdmux.sv
module usb_ep_rdmux
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 8
) (
  input  ep_state_t [NUM_EP-1:0] states,
  input  logic [IDX_W-1:0]       sel,
  input  logic [ADDR_W-1:0]      addr,
  output logic [DATA_W-1:0]      rdata
);
  ep_state_t cur;
  logic      sel_ok;

  always_comb begin
    cur    = '0;
    sel_ok = 1'b0;
    for (int e = 0; e < NUM_EP; e++) begin
      if (sel == IDX_W'(e)) begin
        cur    = states[e];
        sel_ok = 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == RA_SEL) begin
      rdata = DATA_W'(sel);
    end else if (sel_ok) begin
      case (addr)
        RA_CTL:  rdata = ctl_view(cur.en, cur.tgl);
        RA_CFG:  rdata = cur.cfg;
        RA_INT:  rdata = cur.flags;
        RA_STA:  rdata = cur.sta;
        RA_STB:  rdata = cur.stb;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/usb_ep_state_mgr.sv
module usb_ep_state_mgr
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP     = 8,
  parameter int SE0_CYCLES = 4800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_se0,
  input  logic              cpu_rst_mode,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              txn_valid,
  input  logic [2:0]        txn_ep,
  input  logic              txn_ok,
  input  logic [7:0]        txn_int,
  input  logic [7:0]        txn_st0,
  input  logic [7:0]        txn_st1,
  output logic              bus_reset_pulse,
  output logic              cpu_rst_pulse
);
  logic                  se0_hit;
  logic [IDX_W-1:0]      sel_q;
  ep_state_t [NUM_EP-1:0] ep_states;
  logic [NUM_EP-1:0]     ep_en_vec;
  logic [NUM_EP-1:0]     ep_tgl_vec;
  logic [NUM_EP-1:0]     ep_clean_vec;
  logic                  bus_rst_q, cpu_rst_q;

  usb_se0_timer #(.SE0_CYCLES(SE0_CYCLES)) se0_tmr_i (
    .clk(clk), .rst_n(rst_n), .line_se0(line_se0), .se0_hit(se0_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      bus_rst_q <= 1'b0;
      cpu_rst_q <= 1'b0;
    end else begin
      if (cpu_we && cpu_addr == RA_SEL) sel_q <= cpu_wdata[IDX_W-1:0];
      bus_rst_q <= se0_hit;
      cpu_rst_q <= se0_hit && cpu_rst_mode;
    end
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic mine;
    assign mine = cpu_we && (sel_q == IDX_W'(e));

    usb_ep_slot #(.IS_DEFAULT(e == 0)) slot_i (
      .clk(clk), .rst_n(rst_n), .bus_rst(se0_hit),
      .wr_ctl(mine && cpu_addr == RA_CTL),
      .wr_cfg(mine && cpu_addr == RA_CFG),
      .wr_flags(mine && cpu_addr == RA_INT),
      .wdata(cpu_wdata),
      .txn_hit(txn_valid && txn_ep == IDX_W'(e)),
      .txn_ok(txn_ok), .txn_int(txn_int),
      .txn_st0(txn_st0), .txn_st1(txn_st1),
      .state(ep_states[e])
    );

    assign ep_en_vec[e]    = ep_states[e].en;
    assign ep_tgl_vec[e]   = ep_states[e].tgl;
    assign ep_clean_vec[e] = (ep_states[e].flags == '0) &&
                             (ep_states[e].sta == '0) && (ep_states[e].stb == '0);
  end

  usb_ep_rdmux #(.NUM_EP(NUM_EP)) rdmux_i (
    .states(ep_states), .sel(sel_q), .addr(cpu_addr), .rdata(cpu_rdata)
  );

  assign bus_reset_pulse = bus_rst_q;
  assign cpu_rst_pulse   = cpu_rst_q;
endmodule

// File: rtl/usb_ep_state_chk.sv
module usb_ep_state_chk #(
  parameter int NUM_EP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_se0,
  input logic              cpu_rst_mode,
  input logic              se0_hit,
  input logic              bus_reset_pulse,
  input logic              cpu_rst_pulse,
  input logic [NUM_EP-1:0] ep_en_vec,
  input logic [NUM_EP-1:0] ep_tgl_vec,
  input logic [NUM_EP-1:0] ep_clean_vec,
  input logic [2:0]        sel_q,
  input logic [2:0]        cpu_addr,
  input logic [7:0]        cpu_rdata
);
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_pulse |=> !bus_reset_pulse);

  assert_pulse_after_se0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_pulse |-> $past(line_se0));

  assert_hit_to_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    se0_hit |=> bus_reset_pulse);

  assert_teardown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_pulse |-> (!ep_tgl_vec[0] && ((ep_en_vec >> 1) == '0)));

  assert_ep0_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_pulse |-> (ep_en_vec[0] == $past(ep_en_vec[0])));

  assert_cpu_rst_in_bus_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_pulse |-> (bus_reset_pulse && $past(cpu_rst_mode)));

  assert_out_of_range_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_q >= 3'(NUM_EP)) && NUM_EP < 8 && cpu_addr != 3'd5) |-> (cpu_rdata == 8'd0));

  for (genvar e = 0; e < NUM_EP; e++) begin : g_hold
    assert_disabled_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ep_en_vec[e] && $past(!ep_en_vec[e])) |-> (ep_clean_vec[e] && !ep_tgl_vec[e]));
  end
endmodule

bind usb_ep_state_mgr usb_ep_state_chk #(.NUM_EP(NUM_EP)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_se0(line_se0), .cpu_rst_mode(cpu_rst_mode),
  .se0_hit(se0_hit), .bus_reset_pulse(bus_reset_pulse), .cpu_rst_pulse(cpu_rst_pulse),
  .ep_en_vec(ep_en_vec), .ep_tgl_vec(ep_tgl_vec), .ep_clean_vec(ep_clean_vec),
  .sel_q(sel_q), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata)
);

// File: tb/usb_ep_state_mgr_tb.sv
`timescale 1ns/1ps
module usb_ep_state_mgr_tb_top;
  localparam int NEP = 6;
  localparam int SE0 = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_se0 = 0, cpu_rst_mode = 0, cpu_we = 0, txn_valid = 0, txn_ok = 0;
  logic [2:0] cpu_addr = 0, txn_ep = 0;
  logic [7:0] cpu_wdata = 0, txn_int = 0, txn_st0 = 0, txn_st1 = 0;
  logic [7:0] cpu_rdata;
  logic bus_reset_pulse, cpu_rst_pulse;

  always #2.5 clk = ~clk;

  usb_ep_state_mgr #(.NUM_EP(NEP), .SE0_CYCLES(SE0)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_se0(line_se0), .cpu_rst_mode(cpu_rst_mode),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .txn_valid(txn_valid), .txn_ep(txn_ep), .txn_ok(txn_ok), .txn_int(txn_int),
    .txn_st0(txn_st0), .txn_st1(txn_st1),
    .bus_reset_pulse(bus_reset_pulse), .cpu_rst_pulse(cpu_rst_pulse)
  );

  // behavioural reference
  int m_en[8], m_tgl[8], m_cfg[8], m_fl[8], m_sa[8], m_sb[8];
  int m_sel, se0_run, m_bus, m_cpu;
  int nchk = 0, nerr = 0, cyc = 0, bus_seen = 0, cpu_seen = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 8; e++) begin
        m_en[e] = 0; m_tgl[e] = 0; m_cfg[e] = 0; m_fl[e] = 0; m_sa[e] = 0; m_sb[e] = 0;
      end
      m_sel = 0; se0_run = 0; m_bus = 0; m_cpu = 0;
    end else begin
      bit hit;
      hit = line_se0 && (se0_run == SE0 - 1);
      if (!line_se0) se0_run = 0;
      else if (se0_run < SE0) se0_run++;
      m_bus = hit;
      m_cpu = hit && cpu_rst_mode;
      for (int e = 0; e < NEP; e++) begin
        bit mine, th, erst, eclr;
        mine = cpu_we && (m_sel == e);
        th   = txn_valid && (txn_ep == e);
        erst = mine && cpu_addr == 0 && cpu_wdata[1];
        eclr = mine && cpu_addr == 0 && cpu_wdata[2];
        if (hit) begin
          m_tgl[e] = 0;
          if (e != 0) begin m_en[e] = 0; m_fl[e] = 0; m_sa[e] = 0; m_sb[e] = 0; end
        end else if (m_en[e] == 0) begin
          m_tgl[e] = 0; m_fl[e] = 0; m_sa[e] = 0; m_sb[e] = 0;
          if (mine && cpu_addr == 0) m_en[e] = cpu_wdata[0];
          if (mine && cpu_addr == 1) m_cfg[e] = cpu_wdata;
        end else begin
          if (th) m_fl[e] = m_fl[e] | txn_int;
          if (mine && cpu_addr == 2) m_fl[e] = m_fl[e] & ~int'(cpu_wdata);
          if (th) begin m_sa[e] = txn_st0; m_sb[e] = txn_st1; end
          if (erst) begin m_fl[e] = 0; m_sa[e] = 0; m_sb[e] = 0; end
          if (th && txn_ok) m_tgl[e] = 1 - m_tgl[e];
          if (eclr) m_tgl[e] = 0;
          if (mine && cpu_addr == 0) m_en[e] = cpu_wdata[0];
          if (mine && cpu_addr == 1) m_cfg[e] = cpu_wdata;
        end
      end
      if (cpu_we && cpu_addr == 5) m_sel = cpu_wdata & 7;
    end
  end

  function automatic int exp_rd(int a);
    if (a == 5) return m_sel;
    if (a > 5 || m_sel >= NEP) return 0;
    case (a)
      0: return m_en[m_sel] + 8 * m_tgl[m_sel];
      1: return m_cfg[m_sel];
      2: return m_fl[m_sel];
      3: return m_sa[m_sel];
      default: return m_sb[m_sel];
    endcase
  endfunction

  task automatic chk(string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("rdata", int'(cpu_rdata), exp_rd(int'(cpu_addr)));
    chk("bus_reset_pulse", int'(bus_reset_pulse), m_bus);
    chk("cpu_rst_pulse", int'(cpu_rst_pulse), m_cpu);
    bus_seen += int'(bus_reset_pulse);
    cpu_seen += int'(cpu_rst_pulse);
  endtask

  task automatic wr(int a, int d);
    cpu_we = 1; cpu_addr = 3'(a); cpu_wdata = 8'(d);
    tick();
    cpu_we = 0;
  endtask

  task automatic sweep();
    for (int a = 0; a < 8; a++) begin cpu_addr = 3'(a); tick(); end
  endtask

  task automatic txn(int ep, int ok, int fl, int sa, int sb);
    txn_valid = 1; txn_ep = 3'(ep); txn_ok = ok[0];
    txn_int = 8'(fl); txn_st0 = 8'(sa); txn_st1 = 8'(sb);
    tick();
    txn_valid = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nerr++;
      $display("FAIL %s watchdog expired", cur_req);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; sweep();                 // reset state: all zero
    wr(5, 1); wr(0, 1); wr(1, 8'h5A); sweep();
    wr(5, 0); wr(0, 1); wr(1, 8'h40); sweep();
    cur_req = "R8"; wr(5, 1);
    txn(1, 1, 0, 0, 0); txn(1, 1, 0, 0, 0); txn(1, 1, 0, 0, 0); txn(1, 0, 0, 0, 0);
    cpu_addr = 0; tick();
    cur_req = "R10";
    txn(1, 0, 8'h05, 8'h11, 8'h22); txn(1, 1, 8'h30, 8'h33, 8'h44); sweep();
    wr(2, 8'h14); sweep();
    cur_req = "R6"; wr(0, 8'h03); sweep();
    cur_req = "R7"; txn(1, 1, 8'h01, 1, 2); wr(0, 8'h07); sweep();
    txn(1, 1, 0, 0, 0); wr(0, 8'h05); cpu_addr = 0; tick();
    cur_req = "R11";
    txn(1, 1, 0, 0, 0);
    txn_valid = 1; txn_ep = 1; txn_ok = 1; txn_int = 8'hFF; txn_st0 = 9; txn_st1 = 9;
    wr(0, 8'h03); txn_valid = 0; sweep();
    txn_valid = 1; wr(0, 8'h07); txn_valid = 0; sweep();
    cur_req = "R9"; wr(5, 2); wr(1, 8'h77);
    txn(2, 1, 8'hFF, 8'h12, 8'h34); sweep();
    wr(0, 1); txn(2, 1, 8'h0F, 1, 1); wr(0, 0); sweep();
    cur_req = "R2"; wr(5, 7); wr(0, 1); wr(1, 8'hEE); wr(2, 8'hFF); sweep();
    wr(5, 6); wr(0, 1); sweep();
    wr(5, 1); sweep();
    cur_req = "R3";
    line_se0 = 1; repeat (SE0 - 1) tick(); line_se0 = 0; tick(); tick();
    chk("short se0 no pulse", bus_seen, 0);
    wr(5, 3); wr(0, 1); txn(3, 1, 8'h81, 5, 6); wr(5, 0); txn(0, 1, 8'h02, 7, 7);
    line_se0 = 1; repeat (SE0 + 25) tick(); line_se0 = 0; tick();
    chk("one pulse per se0 period", bus_seen, 1);
    chk("no cpu reset with mode clear", cpu_seen, 0);
    cur_req = "R4"; sweep(); wr(5, 1); sweep(); wr(5, 3); sweep();
    cur_req = "R5"; cpu_rst_mode = 1;
    wr(5, 0); txn(0, 1, 0, 0, 0); wr(5, 1); wr(0, 1); txn(1, 1, 0, 0, 0); wr(5, 2);
    line_se0 = 1;
    for (int i = 0; i < SE0 + 4; i++) begin
      cpu_we = 1; cpu_addr = (i % 2) ? 3'd1 : 3'd0; cpu_wdata = 8'(8'h81 + i);
      txn_valid = 1; txn_ep = 0; txn_ok = 1; txn_int = 8'h10; txn_st0 = 8'(i); txn_st1 = 0;
      tick();
    end
    cpu_we = 0; txn_valid = 0; line_se0 = 0; tick();
    chk("cpu reset pulse count", cpu_seen, 1);
    chk("bus reset pulse count", bus_seen, 2);
    cur_req = "R4"; wr(5, 0); sweep(); wr(5, 1); sweep(); wr(5, 2); sweep();
    finish_run();
  end
endmodule